// File: doc/BRIEF.md
# Seconds Counter with Alarm

A timekeeping peripheral on a plain 32-bit register bus. A reference-rate enable is divided by a programmable prescaler into one tick per second, and each tick advances a 62-bit binary seconds count. New time is not written straight into the live count. Software stages it in two holding words and then commits it with a load command. Completion of the load can be polled in the control register.

A 43-bit alarm value is compared with the count on every tick. A per-bit mask selects which bits take part in the compare, and reset leaves every bit taking part. When an armed compare hits, a level interrupt rises and stays high until software disarms. A wake field can make a hit clear the count or halt it. The bus, the reference enable and the counter all run on one clock.

Top module: `secs_alarm_timer`

## Requirements
- R1: After reset the control word reads 0, the time low word reads 0, the interrupt is low and the mask is all ones.
- R2: The prescaler (0x08) keeps 26 bits, alarm high (0x10) keeps bits 10:0, mask high (0x18) keeps bits 29:0 and mode (0x04) keeps bits 3:0. Unkept bits read 0. Alarm low (0x0C) and mask low (0x14) keep all 32 bits.
- R3: While running, a tick occurs once every P+1 cycles with `ref_en` high, where P is the prescaler value. Each tick adds one to the count. The count does not change while the counter is stopped, unless a load, a clear or a wake action acts on it.
- R4: Writing control bit 0 starts counting and writing control bit 1 stops it. Stop wins when both bits are written together. Control bit 0 reads back the running state.
- R5: Writing control bit 4 clears the count and restarts the prescaler phase at the next edge.
- R6: Writes to 0x20 and 0x24 fill the holding words, and the high word keeps bits 29:0. Writing control bit 5 copies the holding words into the count one cycle later. Control bit 5 reads 0 while the copy is pending and 1 once it is done.
- R7: A read of 0x20 returns the live count bits 31:0 and latches count bits 61:32 into a shadow word. A read of 0x24 returns that shadow word. Writing control bit 6 also loads the shadow word from the count.
- R8: A hit occurs on the cycle after a tick when the alarm is armed and the count matches the zero-extended alarm on every bit where the mask is 1.
- R9: Control bit 2 arms the alarm, and armed reads back on bit 2. A hit sets `irq_o` and control bit 7. Both stay set until control bit 3 is written. Control bit 3 also disarms and wins over bit 2.
- R10: If mode bit 1 is set, a hit acts on the counter. With mode bit 2 set, the count becomes 0 instead of stepping. With neither mode bit 2 nor mode bit 3 set, the counter stops and keeps the alarm value. With mode bit 3 set and bit 2 clear, counting carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One reference-clock period per high cycle |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
Read data arrives one cycle after the read is sampled. A committed load lands one edge after the command, and control bit 5 reads 1 on a read issued two edges after the command. The first tick after a start comes P+1 edges later, and a hit, an interrupt or a wake action appears one edge after the tick that produced the matching count. The bench drives on falling edges. Each count check is placed a known number of edges after a start or stop, so the expected values are exact tick counts rather than bounds. Every read result is sampled on the falling edge after the read edge.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int BUS_AW = 6;
    localparam logic [BUS_AW-1:0] A_CTRL   = 6'h00;
    localparam logic [BUS_AW-1:0] A_MODE   = 6'h04;
    localparam logic [BUS_AW-1:0] A_PRESC  = 6'h08;
    localparam logic [BUS_AW-1:0] A_ALM_LO = 6'h0C;
    localparam logic [BUS_AW-1:0] A_ALM_HI = 6'h10;
    localparam logic [BUS_AW-1:0] A_MSK_LO = 6'h14;
    localparam logic [BUS_AW-1:0] A_MSK_HI = 6'h18;
    localparam logic [BUS_AW-1:0] A_TIM_LO = 6'h20;
    localparam logic [BUS_AW-1:0] A_TIM_HI = 6'h24;

    // control word bit positions
    localparam int C_RUN    = 0;
    localparam int C_HALT   = 1;
    localparam int C_ARM    = 2;
    localparam int C_DISARM = 3;
    localparam int C_ZERO   = 4;
    localparam int C_LOAD   = 5;
    localparam int C_SNAP   = 6;
    localparam int C_HIT    = 7;

    // mode word bit positions
    localparam int MODE_W  = 4;
    localparam int M_CAL   = 0;
    localparam int M_WAKE  = 1;
    localparam int M_WRST  = 2;
    localparam int M_WCONT = 3;

    typedef struct packed {
        logic run;
        logic halt;
        logic arm;
        logic disarm;
        logic zero;
        logic load;
        logic snap;
    } cmd_t;
endpackage

// File: rtl/sat_prescaler.sv
module sat_prescaler #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         ref_en,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // >= keeps the divider from running away if the limit is lowered
        tick = en && ref_en && (st_q.cnt >= limit);
        if (clr) begin
            st_d.cnt = '0;
        end else if (en && ref_en) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sat_seconds.sv
module sat_seconds #(
    parameter int W = 62
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] secs;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)       st_d.secs = '0;
        else if (load) st_d.secs = load_val;
        else if (step) st_d.secs = st_q.secs + 1'b1;
    end

    assign count = st_q.secs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sat_match.sv
module sat_match #(
    parameter int TW = 62,
    parameter int AW = 43
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          disarm,
    input  logic          step,
    input  logic [TW-1:0] count,
    input  logic [AW-1:0] alarm,
    input  logic [TW-1:0] mask,
    output logic          armed,
    output logic          hit_now,
    output logic          flag
);
    localparam int PAD = TW - AW;

    typedef struct packed {
        logic armed;
        logic step_q;
        logic flag;
    } st_t;

    st_t          st_d, st_q;
    logic [TW-1:0] target;

    assign target = {{PAD{1'b0}}, alarm};

    always_comb begin
        st_d        = st_q;
        hit_now     = st_q.armed && st_q.step_q && (((count ^ target) & mask) == '0);
        st_d.step_q = step;
        if (arm)     st_d.armed = 1'b1;
        if (disarm)  st_d.armed = 1'b0;
        if (hit_now) st_d.flag  = 1'b1;
        if (disarm)  st_d.flag  = 1'b0;
    end

    assign armed = st_q.armed;
    assign flag  = st_q.flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/secs_alarm_timer.sv
module secs_alarm_timer
    import sat_pkg::*;
#(
    parameter int PRESC_W = 26,
    parameter int TIME_W  = 62,
    parameter int ALARM_W = 43,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int TH_W = TIME_W - DATA_W;
    localparam int AH_W = ALARM_W - DATA_W;

    typedef struct packed {
        logic                running;
        logic                upl_pend;
        logic                upl_done;
        logic [MODE_W-1:0]   mode;
        logic [PRESC_W-1:0]  presc;
        logic [ALARM_W-1:0]  alarm;
        logic [TIME_W-1:0]   mask;
        logic [TIME_W-1:0]   hold;
        logic [TH_W-1:0]     shadow;
        logic [DATA_W-1:0]   rdata;
    } reg_t;

    reg_t              st_d, st_q;
    cmd_t              cmd;
    logic              wr_acc, rd_acc, ctrl_wr;
    logic              tick, hit_now, armed, flag;
    logic              wake_hit, wake_clr, wake_halt, run_eff, cnt_clr;
    logic [TIME_W-1:0] count;
    logic              run_now, pend_now, done_now;

    // command decode
    always_comb begin
        wr_acc     = bus_sel && bus_wr;
        rd_acc     = bus_sel && !bus_wr;
        ctrl_wr    = wr_acc && (bus_addr == A_CTRL);
        cmd.run    = ctrl_wr && bus_wdata[C_RUN];
        cmd.halt   = ctrl_wr && bus_wdata[C_HALT];
        cmd.arm    = ctrl_wr && bus_wdata[C_ARM];
        cmd.disarm = ctrl_wr && bus_wdata[C_DISARM];
        cmd.zero   = ctrl_wr && bus_wdata[C_ZERO];
        cmd.load   = ctrl_wr && bus_wdata[C_LOAD];
        cmd.snap   = ctrl_wr && bus_wdata[C_SNAP];
    end

    // wake actions taken on an alarm hit
    always_comb begin
        wake_hit  = hit_now && st_q.mode[M_WAKE];
        wake_clr  = wake_hit && st_q.mode[M_WRST];
        wake_halt = wake_hit && !st_q.mode[M_WRST] && !st_q.mode[M_WCONT];
        run_eff   = st_q.running && !wake_halt;
        cnt_clr   = cmd.zero || wake_clr;
    end

    sat_prescaler #(.W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (run_eff),
        .ref_en (ref_en),
        .clr    (cnt_clr),
        .limit  (st_q.presc),
        .tick   (tick)
    );

    sat_seconds #(.W(TIME_W)) u_secs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load     (st_q.upl_pend),
        .load_val (st_q.hold),
        .step     (tick),
        .count    (count)
    );

    sat_match #(.TW(TIME_W), .AW(ALARM_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (cmd.arm),
        .disarm  (cmd.disarm),
        .step    (tick),
        .count   (count),
        .alarm   (st_q.alarm),
        .mask    (st_q.mask),
        .armed   (armed),
        .hit_now (hit_now),
        .flag    (flag)
    );

    // register file next state
    always_comb begin
        st_d = st_q;

        st_d.upl_pend = cmd.load;
        if (cmd.load)          st_d.upl_done = 1'b0;
        else if (st_q.upl_pend) st_d.upl_done = 1'b1;

        if (cmd.run)   st_d.running = 1'b1;
        if (cmd.halt)  st_d.running = 1'b0;
        if (wake_halt) st_d.running = 1'b0;

        if (cmd.snap) st_d.shadow = count[TIME_W-1:DATA_W];

        if (wr_acc) begin
            case (bus_addr)
                A_MODE:   st_d.mode                   = bus_wdata[MODE_W-1:0];
                A_PRESC:  st_d.presc                  = bus_wdata[PRESC_W-1:0];
                A_ALM_LO: st_d.alarm[DATA_W-1:0]      = bus_wdata;
                A_ALM_HI: st_d.alarm[ALARM_W-1:DATA_W] = bus_wdata[AH_W-1:0];
                A_MSK_LO: st_d.mask[DATA_W-1:0]       = bus_wdata;
                A_MSK_HI: st_d.mask[TIME_W-1:DATA_W]  = bus_wdata[TH_W-1:0];
                A_TIM_LO: st_d.hold[DATA_W-1:0]       = bus_wdata;
                A_TIM_HI: st_d.hold[TIME_W-1:DATA_W]  = bus_wdata[TH_W-1:0];
                default: ;
            endcase
        end

        if (rd_acc) begin
            st_d.rdata = '0;
            case (bus_addr)
                A_CTRL: begin
                    st_d.rdata[C_RUN]  = st_q.running;
                    st_d.rdata[C_ARM]  = armed;
                    st_d.rdata[C_LOAD] = st_q.upl_done;
                    st_d.rdata[C_HIT]  = flag;
                end
                A_MODE:   st_d.rdata = {{(DATA_W-MODE_W){1'b0}}, st_q.mode};
                A_PRESC:  st_d.rdata = {{(DATA_W-PRESC_W){1'b0}}, st_q.presc};
                A_ALM_LO: st_d.rdata = st_q.alarm[DATA_W-1:0];
                A_ALM_HI: st_d.rdata = {{(DATA_W-AH_W){1'b0}}, st_q.alarm[ALARM_W-1:DATA_W]};
                A_MSK_LO: st_d.rdata = st_q.mask[DATA_W-1:0];
                A_MSK_HI: st_d.rdata = {{(DATA_W-TH_W){1'b0}}, st_q.mask[TIME_W-1:DATA_W]};
                A_TIM_LO: begin
                    st_d.rdata  = count[DATA_W-1:0];
                    st_d.shadow = count[TIME_W-1:DATA_W];
                end
                A_TIM_HI: st_d.rdata = {{(DATA_W-TH_W){1'b0}}, st_q.shadow};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = flag;
    assign run_now   = st_q.running;
    assign pend_now  = st_q.upl_pend;
    assign done_now  = st_q.upl_done;
endmodule

// File: rtl/secs_alarm_timer_chk.sv
module secs_alarm_timer_chk
    import sat_pkg::*;
#(
    parameter int TIME_W = 62,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic              run_now,
    input logic              pend_now,
    input logic              done_now,
    input logic              hit_now,
    input logic              armed,
    input logic [TIME_W-1:0] count
);
    logic ctrl_wr;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == A_CTRL);

    assert_load_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_now && !(ctrl_wr && bus_wdata[C_LOAD]) |=> done_now);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !(ctrl_wr && bus_wdata[C_DISARM]) |=> irq_o);

    assert_hit_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(armed));

    assert_halt_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && bus_wdata[C_HALT] |=> !run_now);

    assert_frozen_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_now && !pend_now && !(ctrl_wr && bus_wdata[C_ZERO]) && !hit_now |=> $stable(count));
endmodule

bind secs_alarm_timer secs_alarm_timer_chk #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .run_now   (run_now),
    .pend_now  (pend_now),
    .done_now  (done_now),
    .hit_now   (hit_now),
    .armed     (armed),
    .count     (count)
);

// File: tb/secs_alarm_timer_tb.sv
module secs_alarm_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b1;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    secs_alarm_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_en    (ref_en),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    // {offset, written value, value read back}
    localparam int NV = 9;
    localparam logic [69:0] VEC [NV] = '{
        {6'h08, 32'hFFFF_FFFF, 32'h03FF_FFFF},
        {6'h0C, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
        {6'h10, 32'hFFFF_FFFF, 32'h0000_07FF},
        {6'h14, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
        {6'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {6'h18, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
        {6'h04, 32'hFFFF_FFFF, 32'h0000_000F},
        {6'h04, 32'hFFFF_FFF0, 32'h0000_0000},
        {6'h08, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr32(input logic [5:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd32(input logic [5:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    task automatic chk_rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd32(a, v);
        check(tag, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk_rd("R1 ctrl", 6'h00, 32'h0);
        chk_rd("R1 time lo", 6'h20, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        chk_rd("R1 mask hi", 6'h18, 32'h3FFF_FFFF);

        // R2 register widths, table driven
        for (int i = 0; i < NV; i++) begin
            wr32(VEC[i][69:64], VEC[i][63:32]);
            chk_rd("R2 width", VEC[i][69:64], VEC[i][31:0]);
        end

        // R6 load handshake, R7 shadow and snapshot
        wr32(6'h24, 32'h0000_002A);
        wr32(6'h20, 32'h0);
        wr32(6'h00, 32'h20);
        chk_rd("R6 pending", 6'h00, 32'h00);
        chk_rd("R6 done", 6'h00, 32'h20);
        chk_rd("R7 stale shadow", 6'h24, 32'h0);
        wr32(6'h00, 32'h40);
        chk_rd("R7 snapshot", 6'h24, 32'h2A);

        // R6 masking of holding high word
        wr32(6'h20, 32'h1234_5678);
        wr32(6'h24, 32'hFFFF_FFFF);
        wr32(6'h00, 32'h20);
        idle(2);
        chk_rd("R6 load lo", 6'h20, 32'h1234_5678);
        chk_rd("R6 load hi", 6'h24, 32'h3FFF_FFFF);

        // R5 clear
        wr32(6'h00, 32'h10);
        chk_rd("R5 clear lo", 6'h20, 32'h0);
        chk_rd("R5 clear hi", 6'h24, 32'h0);

        // R3 prescaler 4 -> 50 edges give 10 ticks
        wr32(6'h08, 32'd4);
        wr32(6'h00, 32'h10);
        wr32(6'h00, 32'h01);
        idle(49);
        wr32(6'h00, 32'h02);
        chk_rd("R3 ticks presc4", 6'h20, 32'd10);
        chk_rd("R4 stopped", 6'h00, 32'h20);
        idle(20);
        chk_rd("R4 hold while stopped", 6'h20, 32'd10);
        wr32(6'h00, 32'h03);
        chk_rd("R4 stop wins", 6'h00, 32'h20);

        // R5 phase restart: one tick in 9 edges after clear
        wr32(6'h00, 32'h10);
        wr32(6'h00, 32'h01);
        idle(2);
        wr32(6'h00, 32'h10);
        idle(8);
        wr32(6'h00, 32'h02);
        chk_rd("R5 phase restart", 6'h20, 32'd1);

        // R3 prescaler 0 -> tick every edge
        wr32(6'h08, 32'd0);
        wr32(6'h00, 32'h10);
        wr32(6'h00, 32'h01);
        idle(9);
        wr32(6'h00, 32'h02);
        chk_rd("R3 ticks presc0", 6'h20, 32'd10);

        // R8 masked compare, alarm 0x13 with low nibble ignored
        wr32(6'h00, 32'h10);
        wr32(6'h0C, 32'h13);
        wr32(6'h10, 32'h0);
        wr32(6'h14, 32'hFFFF_FFF0);
        wr32(6'h00, 32'h05);
        idle(9);
        wr32(6'h00, 32'h02);
        check("R8 no hit below 16", {31'b0, irq}, 32'h0);
        chk_rd("R9 armed readback", 6'h00, 32'h24);
        wr32(6'h00, 32'h01);
        idle(19);
        wr32(6'h00, 32'h02);
        check("R8 masked hit", {31'b0, irq}, 32'h1);
        chk_rd("R9 hit status", 6'h00, 32'hA4);

        // R9 sticky until disarm, disarm wins over arm
        idle(10);
        check("R9 sticky", {31'b0, irq}, 32'h1);
        wr32(6'h00, 32'h0C);
        check("R9 cleared", {31'b0, irq}, 32'h0);
        chk_rd("R9 disarm wins", 6'h00, 32'h20);

        // R10 wake clears count: count = 30 mod 8
        wr32(6'h14, 32'hFFFF_FFFF);
        wr32(6'h04, 32'h6);
        wr32(6'h0C, 32'd7);
        wr32(6'h00, 32'h10);
        wr32(6'h00, 32'h05);
        idle(29);
        wr32(6'h00, 32'h02);
        chk_rd("R10 wake clear", 6'h20, 32'd6);
        check("R10 wake clear irq", {31'b0, irq}, 32'h1);
        wr32(6'h00, 32'h08);

        // R10 wake halts at alarm value
        wr32(6'h04, 32'h2);
        wr32(6'h0C, 32'd4);
        wr32(6'h00, 32'h10);
        wr32(6'h00, 32'h05);
        idle(19);
        chk_rd("R10 wake halt ctrl", 6'h00, 32'hA4);
        chk_rd("R10 wake halt count", 6'h20, 32'd4);
        wr32(6'h00, 32'h08);
        wr32(6'h04, 32'h0);

        // R7 read across a carry stays consistent
        wr32(6'h20, 32'hFFFF_FFFF);
        wr32(6'h24, 32'h0);
        wr32(6'h00, 32'h20);
        idle(2);
        wr32(6'h00, 32'h01);
        chk_rd("R7 lo before carry", 6'h20, 32'hFFFF_FFFF);
        chk_rd("R7 hi latched", 6'h24, 32'h0);
        chk_rd("R7 lo after carry", 6'h20, 32'd1);
        chk_rd("R7 hi after carry", 6'h24, 32'd1);
        wr32(6'h00, 32'h02);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule